// File: doc/BRIEF.md
# Unpacked-BCD Multiply/Divide Adjust Unit

This unit performs the two byte-adjust steps used around unpacked-BCD multiplication and division. It takes a 16-bit accumulator (high byte AH, low byte AL), an 8-bit immediate base, an operation select and a start strobe. It returns a new accumulator, six arithmetic flags, a divide-error indication and a one-cycle done strobe.

The split operation (op_sel = 0) splits AL into digits in the given base. An 8-step restoring divider places AL / base in AH and AL % base in AL. A base of zero is found in one extra cycle and reported as a divide error, with the stored results left as they were. The merge operation (op_sel = 1) is the reverse step. A shift-add multiplier forms AH * base and AL is added to that product. The low byte of the sum becomes AL and AH is cleared. The merge result is held back so that it completes on a fixed 60-cycle schedule.

Operands are captured on the clock edge that accepts start. The results are registered and stay on the outputs until the next operation completes.

Top module: `bcd_muldiv_adjust`

## Requirements
- R1: While rst_n is low at a clock edge, acc_out becomes 0, all six flags become 0, and done and div_err become 0.
- R2: When a split operation completes with a nonzero base, acc_out[15:8] equals AL / base and acc_out[7:0] equals AL % base, using the AL and base captured at start. The captured AH has no effect on the result.
- R3: After a valid split, sf is bit 7 of the new AL, zf is 1 exactly when the new AL is zero, and pf is 1 exactly when the new AL holds an even number of one bits. of, cf and af are 0.
- R4: A split with base 0 raises done and div_err together after the 2nd rising edge, counting the accepting edge as the 1st. acc_out and all flags keep the values they had before.
- R5: A split with a nonzero base raises done after the 11th rising edge, counting the accepting edge as the 1st.
- R6: When a merge completes, acc_out[15:8] is 0 and acc_out[7:0] is the low byte of AH * base + AL.
- R7: After a merge, sf, zf and pf follow the rule of R3 on the new AL. cf is the carry out of bit 7 and af is the carry out of bit 3 of the 8-bit sum (AH * base mod 256) + AL. of is 1 when both addends have the same bit 7 and the sum's bit 7 differs from it.
- R8: A merge raises done after the 60th rising edge, counting the accepting edge as the 1st. The merge never raises div_err, even for base 0.
- R9: done is high for exactly one cycle per accepted operation, and div_err is high only together with done.
- R10: A start that arrives while an operation is in progress is ignored. It does not change the running operation's result or its completion time, and it does not start another operation.
- R11: acc_out and the flags change only in a cycle where done rises with div_err low, and otherwise hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Requests an operation; accepted only when idle |
| op_sel | input | 1 | 0 = split (divide AL by base), 1 = merge (AH * base + AL) |
| acc_in | input | 16 | Accumulator operand: [15:8] AH, [7:0] AL |
| base_in | input | 8 | Immediate base |
| acc_out | output | 16 | Result accumulator |
| sf | output | 1 | Sign flag of the new AL |
| zf | output | 1 | Zero flag of the new AL |
| pf | output | 1 | Even-parity flag of the new AL |
| of | output | 1 | Signed overflow of the merge low-byte add; 0 after split |
| cf | output | 1 | Carry out of bit 7 of the merge low-byte add; 0 after split |
| af | output | 1 | Carry out of bit 3 of the merge low-byte add; 0 after split |
| div_err | output | 1 | Divide error (split with base 0), pulses with done |
| done | output | 1 | One-cycle completion strobe |

## Verification
The latency properties assume a start is accepted only when the unit is idle. They also assume the operation select captured at acceptance decides which latency applies. The bench therefore drives operands only together with a start in idle cycles, except in the deliberate busy-start test, and that test keeps its stray start well inside the running window. The hold property assumes no reset arrives in the middle of an operation, so reset is applied only once, at time zero. The sweeps cover every AL value under several bases, including 1, 10 and 255. For the merge they also cover every AH value. Base 0 is exercised under both operations.

// File: rtl/bcd_adj_pkg.sv
// Package: shared types for the BCD adjust unit.
// Assumes: an 8-bit byte datapath is the intended use, though widths are parameters elsewhere.
package bcd_adj_pkg;

    // Operation encoding on op_sel
    typedef enum logic {
        OP_SPLIT = 1'b0,
        OP_MERGE = 1'b1
    } adj_op_e;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_DIV   = 3'd2,
        ST_MUL   = 3'd3,
        ST_PAD   = 3'd4
    } adj_state_e;

    // Flag bundle produced by the result stage
    typedef struct packed {
        logic sf;
        logic zf;
        logic pf;
        logic of;
        logic cf;
        logic af;
    } adj_flags_t;

endpackage

// File: rtl/bcd_restoring_div.sv
// Restoring divider: one quotient bit per step, W steps after a load.
// Assumes: divisor is nonzero (the sequencer filters zero) and load/step are never high together.
module bcd_restoring_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);

    logic [W-1:0] quo_q;
    logic [W-1:0] rem_q;
    logic [W-1:0] dsr_q;
    logic [W:0]   trial;
    logic [W:0]   diff;
    logic [W:0]   rem_n;
    logic         fits;
    logic         unused_rem_top;

    // Trial subtraction of the divisor from the shifted partial remainder
    always_comb begin
        trial = {rem_q, quo_q[W-1]};
        diff  = trial - {1'b0, dsr_q};
        fits  = (trial >= {1'b0, dsr_q});
        rem_n = fits ? diff : trial;
    end

    assign unused_rem_top = rem_n[W];

    // Operand load and one restoring iteration per step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            dsr_q <= '0;
        end else if (load) begin
            quo_q <= dividend;
            rem_q <= '0;
            dsr_q <= divisor;
        end else if (step) begin
            quo_q <= {quo_q[W-2:0], fits};
            rem_q <= rem_n[W-1:0];
        end
    end

    assign quotient  = quo_q;
    assign remainder = rem_q;

endmodule

// File: rtl/bcd_shift_add_mul.sv
// Shift-add multiplier: one multiplier bit per step, W steps after a load.
// Assumes: load and step are never high together; the product is read after W steps.
module bcd_shift_add_mul #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] product
);

    localparam int PW = 2 * W;

    logic [PW-1:0] prod_q;
    logic [PW-1:0] mcand_q;
    logic [W-1:0]  mplier_q;

    // Conditional add of the shifted multiplicand, then shift both operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q   <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
        end else if (load) begin
            prod_q   <= '0;
            mcand_q  <= {{W{1'b0}}, mcand};
            mplier_q <= mplier;
        end else if (step) begin
            if (mplier_q[0]) begin
                prod_q <= prod_q + mcand_q;
            end
            mcand_q  <= {mcand_q[PW-2:0], 1'b0};
            mplier_q <= {1'b0, mplier_q[W-1:1]};
        end
    end

    assign product = prod_q;

endmodule

// File: rtl/bcd_adj_result.sv
// Result stage: forms the new accumulator and flags from the datapath outputs.
// Assumes: inputs are stable (engines finished) when the sequencer latches the outputs.
module bcd_adj_result
    import bcd_adj_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           is_merge,
    input  logic [W-1:0]   quotient,
    input  logic [W-1:0]   remainder,
    input  logic [2*W-1:0] product,
    input  logic [W-1:0]   addend,
    output logic [2*W-1:0] res_acc,
    output adj_flags_t     res_flags
);

    localparam int PW = 2 * W;

    logic [PW-1:0] sum_full;
    logic [W:0]    sum_low;
    logic [4:0]    sum_nib;
    logic [W-1:0]  new_al;
    logic          unused_sum_hi;
    logic          unused_nib;

    // Full-width add plus the low-byte and low-nibble adds that produce the carries
    always_comb begin
        sum_full = product + {{W{1'b0}}, addend};
        sum_low  = {1'b0, product[W-1:0]} + {1'b0, addend};
        sum_nib  = {1'b0, product[3:0]} + {1'b0, addend[3:0]};
    end

    assign unused_sum_hi = ^sum_full[PW-1:W];
    assign unused_nib    = ^sum_nib[3:0];

    // Pick the result and flags for the selected operation
    always_comb begin
        if (is_merge) begin
            new_al       = sum_full[W-1:0];
            res_acc      = {{W{1'b0}}, new_al};
            res_flags.cf = sum_low[W];
            res_flags.af = sum_nib[4];
            res_flags.of = (product[W-1] == addend[W-1]) && (sum_low[W-1] != product[W-1]);
        end else begin
            new_al       = remainder;
            res_acc      = {quotient, remainder};
            res_flags.cf = 1'b0;
            res_flags.af = 1'b0;
            res_flags.of = 1'b0;
        end
        res_flags.sf = new_al[W-1];
        res_flags.zf = (new_al == '0);
        res_flags.pf = ~(^new_al);
    end

endmodule

// File: rtl/bcd_muldiv_adjust.sv
// Top: sequences the split (divide) and merge (multiply-add) byte adjusts.
// Assumes: MERGE_CYCLES > W + 1 so that the multiplier finishes inside the merge window;
// operands are captured only on the accepting edge.
module bcd_muldiv_adjust
    import bcd_adj_pkg::*;
#(
    parameter int W            = 8,
    parameter int MERGE_CYCLES = 60
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           op_sel,
    input  logic [2*W-1:0] acc_in,
    input  logic [W-1:0]   base_in,
    output logic [2*W-1:0] acc_out,
    output logic           sf,
    output logic           zf,
    output logic           pf,
    output logic           of,
    output logic           cf,
    output logic           af,
    output logic           div_err,
    output logic           done
);

    localparam int CNT_W      = $clog2(MERGE_CYCLES + 1);
    localparam int SPLIT_LAST = W + 2;
    localparam int MUL_LAST   = W;
    localparam int MERGE_LAST = MERGE_CYCLES - 1;

    adj_state_e     state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]   al_q;
    logic [W-1:0]   base_q;
    logic           is_merge_q;
    logic           busy;
    logic           accept;
    logic           div_load;
    logic           div_step;
    logic           mul_load;
    logic           mul_step;
    logic           finish_ok;
    logic           finish_err;
    logic [W-1:0]   quotient;
    logic [W-1:0]   remainder;
    logic [2*W-1:0] product;
    logic [2*W-1:0] res_acc;
    adj_flags_t     res_flags;
    logic [2*W-1:0] acc_q;
    adj_flags_t     flags_q;
    logic           done_q;
    logic           err_q;

    // Control decode from the current state and counter
    always_comb begin
        busy       = (state_q != ST_IDLE);
        accept     = (state_q == ST_IDLE) && start;
        mul_load   = accept && (op_sel == OP_MERGE);
        mul_step   = (state_q == ST_MUL);
        div_load   = (state_q == ST_CHECK) && (base_q != '0);
        div_step   = (state_q == ST_DIV) && (cnt_q != CNT_W'(SPLIT_LAST));
        finish_err = (state_q == ST_CHECK) && (base_q == '0);
        finish_ok  = ((state_q == ST_DIV) && (cnt_q == CNT_W'(SPLIT_LAST)))
                  || ((state_q == ST_PAD) && (cnt_q == CNT_W'(MERGE_LAST)));
    end

    // Sequencer state, edge counter and operand capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            al_q       <= '0;
            base_q     <= '0;
            is_merge_q <= 1'b0;
        end else begin
            if (accept) begin
                cnt_q      <= CNT_W'(1);
                al_q       <= acc_in[W-1:0];
                base_q     <= base_in;
                is_merge_q <= (op_sel == OP_MERGE);
            end else if (busy) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= (op_sel == OP_MERGE) ? ST_MUL : ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    state_q <= (base_q == '0) ? ST_IDLE : ST_DIV;
                end
                ST_DIV: begin
                    if (cnt_q == CNT_W'(SPLIT_LAST)) begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_MUL: begin
                    if (cnt_q == CNT_W'(MUL_LAST)) begin
                        state_q <= ST_PAD;
                    end
                end
                ST_PAD: begin
                    if (cnt_q == CNT_W'(MERGE_LAST)) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Divide engine for the split operation
    bcd_restoring_div #(.W(W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (div_load),
        .step      (div_step),
        .dividend  (al_q),
        .divisor   (base_q),
        .quotient  (quotient),
        .remainder (remainder)
    );

    // Multiply engine for the merge operation
    bcd_shift_add_mul #(.W(W)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (mul_load),
        .step    (mul_step),
        .mcand   (base_in),
        .mplier  (acc_in[2*W-1:W]),
        .product (product)
    );

    // Result and flag formation
    bcd_adj_result #(.W(W)) u_res (
        .is_merge  (is_merge_q),
        .quotient  (quotient),
        .remainder (remainder),
        .product   (product),
        .addend    (al_q),
        .res_acc   (res_acc),
        .res_flags (res_flags)
    );

    // Output registers: results load on a good finish, strobes pulse on any finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            flags_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= finish_ok || finish_err;
            err_q  <= finish_err;
            if (finish_ok) begin
                acc_q   <= res_acc;
                flags_q <= res_flags;
            end
        end
    end

    assign acc_out = acc_q;
    assign sf      = flags_q.sf;
    assign zf      = flags_q.zf;
    assign pf      = flags_q.pf;
    assign of      = flags_q.of;
    assign cf      = flags_q.cf;
    assign af      = flags_q.af;
    assign div_err = err_q;
    assign done    = done_q;

endmodule

// File: rtl/bcd_muldiv_adjust_chk.sv
// Checker: temporal properties of the adjust unit, bound to the top module.
// Assumes: reset is only applied between operations.
module bcd_muldiv_adjust_chk #(
    parameter int W            = 8,
    parameter int MERGE_CYCLES = 60
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           merge_q,
    input logic [2*W-1:0] acc_out,
    input logic           sf,
    input logic           zf,
    input logic           pf,
    input logic           of,
    input logic           cf,
    input logic           af,
    input logic           div_err,
    input logic           done
);

    logic [15:0] lat_q;

    // Edges elapsed since the accepting edge, counting that edge as 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (start && !busy) begin
            lat_q <= 16'd1;
        end else if (busy) begin
            lat_q <= lat_q + 16'd1;
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |-> done);

    // R4
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |-> ($stable(acc_out) && $stable({sf, zf, pf, of, cf, af})));

    // R4
    err_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |-> (lat_q == 16'd2));

    // R5
    split_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_err && !merge_q) |-> (lat_q == 16'(W + 3)));

    // R3
    split_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_err && !merge_q) |-> (!of && !cf && !af));

    // R6
    merge_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && merge_q) |-> (acc_out[2*W-1:W] == '0));

    // R8
    merge_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && merge_q) |-> (lat_q == 16'(MERGE_CYCLES) && !div_err));

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_err) |-> (zf == (acc_out[W-1:0] == '0)));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(merge_q));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(acc_out));

endmodule

bind bcd_muldiv_adjust bcd_muldiv_adjust_chk #(
    .W            (W),
    .MERGE_CYCLES (MERGE_CYCLES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .merge_q (is_merge_q),
    .acc_out (acc_out),
    .sf      (sf),
    .zf      (zf),
    .pf      (pf),
    .of      (of),
    .cf      (cf),
    .af      (af),
    .div_err (div_err),
    .done    (done)
);

// File: tb/sim_bcd_muldiv_adjust.sv
// Bench: sweeps split and merge operations and compares against arithmetic expectations.
module sim_bcd_muldiv_adjust;

    localparam int CLK_PERIOD = 10;
    localparam int MERGE_LAT  = 60;
    localparam int SPLIT_LAT  = 11;
    localparam int ERR_LAT    = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_sel = 1'b0;
    logic [15:0] acc_in = '0;
    logic [7:0]  base_in = '0;
    logic [15:0] acc_out;
    logic        sf, zf, pf, of, cf, af, div_err, done;

    int n_chk  = 0;
    int n_fail = 0;
    int lat_seen;
    logic err_seen;

    bcd_muldiv_adjust u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .acc_in(acc_in), .base_in(base_in), .acc_out(acc_out),
        .sf(sf), .zf(zf), .pf(pf), .of(of), .cf(cf), .af(af),
        .div_err(div_err), .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Launch one operation; optionally inject a stray start while busy (R10)
    task automatic run_op(input logic op, input logic [15:0] ax,
                          input logic [7:0] b, input bit stray);
        @(negedge clk);
        op_sel = op; acc_in = ax; base_in = b; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        acc_in = ~ax; base_in = ~b; op_sel = ~op;
        lat_seen = 1;
        err_seen = 1'b0;
        while (!done && lat_seen < MERGE_LAT + 20) begin
            if (stray && lat_seen == 3) start = 1'b1;
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            lat_seen++;
        end
        err_seen = div_err;
    endtask

    function automatic logic [5:0] flag_exp(input logic [7:0] al, input logic o,
                                            input logic c, input logic a);
        return {al[7], (al == 8'h00), ~(^al), o, c, a};
    endfunction

    task automatic check_split(input logic [15:0] ax, input logic [7:0] b);
        logic [7:0] q, r;
        q = ax[7:0] / b;
        r = ax[7:0] % b;
        run_op(1'b0, ax, b, 1'b0);
        chk("R5", "split latency", lat_seen, SPLIT_LAT);
        chk("R2", "split acc", acc_out, {q, r});
        chk("R3", "split flags", {sf, zf, pf, of, cf, af}, flag_exp(r, 1'b0, 1'b0, 1'b0));
        chk("R9", "split div_err", err_seen, 1'b0);
    endtask

    task automatic check_merge(input logic [15:0] ax, input logic [7:0] b, input bit stray);
        int p, s, nib;
        logic [7:0] res;
        logic o;
        p   = int'(ax[15:8]) * int'(b);
        s   = (p & 255) + int'(ax[7:0]);
        nib = (p & 15) + int'(ax[3:0]);
        res = s[7:0];
        o   = (p[7] == ax[7]) && (res[7] != p[7]);
        run_op(1'b1, ax, b, stray);
        chk(stray ? "R10" : "R8", "merge latency", lat_seen, MERGE_LAT);
        chk(stray ? "R10" : "R6", "merge acc", acc_out, {8'h00, res});
        chk("R7", "merge flags", {sf, zf, pf, of, cf, af},
            flag_exp(res, o, s > 255, nib > 15));
        chk("R8", "merge div_err", err_seen, 1'b0);
    endtask

    task automatic check_zero_base(input logic [15:0] ax);
        logic [15:0] prev_acc;
        logic [5:0]  prev_flags;
        prev_acc   = acc_out;
        prev_flags = {sf, zf, pf, of, cf, af};
        run_op(1'b0, ax, 8'h00, 1'b0);
        chk("R4", "zero-base latency", lat_seen, ERR_LAT);
        chk("R4", "zero-base div_err", err_seen, 1'b1);
        chk("R4", "zero-base acc hold", acc_out, prev_acc);
        chk("R4", "zero-base flag hold", {sf, zf, pf, of, cf, af}, prev_flags);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] held;
        logic [7:0]  split_bases [6] = '{8'd1, 8'd10, 8'd255, 8'd7, 8'd16, 8'd128};
        logic [7:0]  merge_bases [4] = '{8'd0, 8'd1, 8'd10, 8'd255};

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "reset acc", acc_out, 16'h0000);
        chk("R1", "reset flags", {sf, zf, pf, of, cf, af}, 6'b0);
        chk("R1", "reset strobes", {done, div_err}, 2'b00);

        // R2 R3 R5: every AL under several bases, AH scrambled
        foreach (split_bases[i]) begin
            for (int al = 0; al < 256; al++) begin
                check_split({8'((al * 13 + 5) & 255), 8'(al)}, split_bases[i]);
            end
        end

        // R4: zero base after differing prior results
        for (int al = 0; al < 256; al += 3) begin
            check_split({8'h5A, 8'(al)}, 8'd9);
            check_zero_base({8'(al), 8'(al ^ 8'hC3)});
        end

        // R6 R7 R8: every AH under several bases
        foreach (merge_bases[i]) begin
            for (int ah = 0; ah < 256; ah++) begin
                check_merge({8'(ah), 8'((ah * 37 + 11) & 255)}, merge_bases[i], 1'b0);
            end
        end

        // R6 R7: every AL with fixed AH and base 10
        for (int al = 0; al < 256; al++) begin
            check_merge({8'd7, 8'(al)}, 8'd10, 1'b0);
        end

        // R10: stray start while busy, both operations
        check_merge(16'h0905, 8'd10, 1'b1);
        check_merge(16'hF3A1, 8'd255, 1'b1);
        run_op(1'b0, 16'h00F7, 8'd10, 1'b1);
        chk("R10", "split with stray start latency", lat_seen, SPLIT_LAT);
        chk("R10", "split with stray start acc", acc_out, 16'h1807);

        // R11: outputs hold and done stays low while idle
        held = acc_out;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R11", "idle hold acc", acc_out, held);
            chk("R9", "idle done low", done, 1'b0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule